// File: doc/BRIEF.md
# Trap Entry Control Unit

This unit performs the state changes that happen when a hart takes a trap, whether a synchronous exception or an asynchronous interrupt. When a trap is requested, it picks the handler level, supervisor or machine, from the current privilege and one of two delegation masks. In the same clock edge it updates the interrupt-enable stack in the status word, the cause, exception PC and trap-value registers of the chosen level, and the current privilege. While the request is high, it drives the handler address on a combinational output.

The unit owns the status word, the supervisor and machine cause, exception-PC and trap-value registers, and the privilege register. A simple select/write/read port reaches all of them, so the surrounding pipeline can save and restore them and can place the hart at any privilege. Both delegation masks and both trap-vector registers are inputs that live elsewhere. Trap return and instruction decode happen outside this unit.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, every owned register reads zero, except the privilege, which reads 3 (machine). Privilege encoding: 0 user, 1 supervisor, 3 machine.
- R2: An interrupt consults the interrupt delegation mask and an exception consults the exception delegation mask. The bit tested is the one indexed by the (remapped) cause code.
- R3: A trap taken at machine privilege always goes to machine level, whatever the masks hold.
- R4: On supervisor entry, status bit 5 takes the old bit 1, bit 8 takes 1 if the old privilege was supervisor and 0 if it was user, and bit 1 is cleared. No other status bit changes.
- R5: On machine entry, status bit 7 takes the old bit 3, bits 12:11 take the old privilege, and bit 3 is cleared. No other status bit changes.
- R6: The cause register of the handling level receives the cause code in its low bits and the interrupt flag in bit 31.
- R7: The exception PC of the handling level receives the current PC, and the privilege becomes 1 for a supervisor entry or 3 for a machine entry. The other level's registers keep their values.
- R8: While a trap is requested, the redirect output equals the handling level's vector with bits 1:0 cleared. If the trap is an interrupt and the vector's bits 1:0 equal 1, the cause code times 4 is added.
- R9: For exceptions with codes 0, 1, 4, 5, 6, 7, 12, 13 and 15, the trap value receives the faulting address. For all other exception codes and for every interrupt it receives zero.
- R10: An exception with code 8 (environment call) is recorded as 8 from user, 9 from supervisor and 11 from machine. Delegation tests the recorded code.
- R11: The port selects registers as follows: 0 status (bits 1, 3, 5, 7, 8 and 12:11 stored, others read 0), 1/2/3 supervisor cause/PC/value, 4/5/6 machine cause/PC/value, 7 privilege. A write takes effect at the clock edge. A privilege write of 2 stores 0.
- R12: When a trap and a register write arrive in the same cycle, the trap's updates take effect and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | 5 | Cause code before remapping |
| cur_pc | input | 32 | PC of the trapping instruction |
| fault_addr | input | 32 | Faulting address for address-related causes |
| irq_deleg | input | 32 | Interrupt delegation mask |
| exc_deleg | input | 32 | Exception delegation mask |
| s_vec | input | 32 | Supervisor trap vector (bits 1:0 select vectoring) |
| m_vec | input | 32 | Machine trap vector (bits 1:0 select vectoring) |
| redirect_pc | output | 32 | Handler address, valid while trap_req is high |
| csr_we | input | 1 | Register write enable |
| csr_sel | input | 3 | Register select |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Selected register value |
| cur_priv | output | 2 | Current privilege |

## Verification
The hardest cases to reach are delegation decisions that hinge on remapped cause codes. One such case is an environment call from supervisor whose delegation bit 8 is set but bit 9 is clear, so it must still reach machine level. Reaching it needs a prepared privilege, then a crafted mask, then the trap. The directed sequence first writes the privilege through the register port, sets only the relevant mask bit, and issues the call. A long random phase then mixes register writes, privilege changes and traps, so that user, supervisor and machine origins, vectored and direct modes, and same-cycle write collisions all recur. A behavioural model checks every one of those cycles.

// File: rtl/trap_pkg.sv
// Package: shared constants and helpers for the trap entry unit.
// Assumes a 32-bit machine word and the conventional cause numbering.
package trap_pkg;
    localparam int XLEN   = 32;
    localparam int CODE_W = $clog2(XLEN);

    localparam logic [1:0] PRV_U = 2'd0;
    localparam logic [1:0] PRV_S = 2'd1;
    localparam logic [1:0] PRV_M = 2'd3;

    // register port selects
    localparam logic [2:0] SEL_STATUS = 3'd0;
    localparam logic [2:0] SEL_PRIV   = 3'd7;

    // status field positions (a save/restore image consumed elsewhere)
    localparam int ST_SIE  = 1;
    localparam int ST_MIE  = 3;
    localparam int ST_SPIE = 5;
    localparam int ST_MPIE = 7;
    localparam int ST_SPP  = 8;
    localparam int ST_MPP  = 11;

    localparam int ECALL_CODE = 8;

    // true for exception codes that carry a faulting address
    function automatic logic addr_cause(input int unsigned c);
        case (c)
            0, 1, 4, 5, 6, 7, 12, 13, 15: addr_cause = 1'b1;
            default:                      addr_cause = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/trap_route.sv
// Module: trap_route
// Decides the handling level, the recorded cause code and the trap value.
// Assumes the privilege is never 2 (the register file forbids it).
module trap_route
    import trap_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int CW = CODE_W
) (
    input  logic          irq,
    input  logic [CW-1:0] code,
    input  logic [1:0]    priv,
    input  logic [W-1:0]  irq_deleg,
    input  logic [W-1:0]  exc_deleg,
    input  logic [W-1:0]  fault_addr,
    output logic [CW-1:0] eff_code,
    output logic          to_s,
    output logic [W-1:0]  tval
);
    logic [W-1:0] mask;

    // environment call: code 8 becomes 8 + privilege (8, 9, 11)
    always_comb begin
        eff_code = code;
        if (!irq && (code == CW'(ECALL_CODE)))
            eff_code = {code[CW-1:2], priv};
    end

    // delegation only from supervisor or below
    always_comb begin
        mask = irq ? irq_deleg : exc_deleg;
        to_s = (priv <= PRV_S) && mask[eff_code];
    end

    // trap value only for address-carrying exceptions
    always_comb begin
        tval = '0;
        if (!irq && addr_cause(32'(eff_code)))
            tval = fault_addr;
    end
endmodule

// File: rtl/trap_vector.sv
// Module: trap_vector
// Computes the handler address from the selected vector register.
// Assumes vector bits 1:0 == 1 request vectored interrupt entry.
module trap_vector
    import trap_pkg::*;
#(
    parameter int W        = XLEN,
    parameter int CW       = CODE_W,
    parameter bit VECTORED = 1'b1
) (
    input  logic          to_s,
    input  logic          irq,
    input  logic [CW-1:0] code,
    input  logic [W-1:0]  s_vec,
    input  logic [W-1:0]  m_vec,
    output logic [W-1:0]  target
);
    logic [W-1:0] vec;
    logic [W-1:0] base;

    // pick the level's vector and clear its mode bits
    always_comb begin
        vec  = to_s ? s_vec : m_vec;
        base = {vec[W-1:2], 2'b00};
    end

    generate
        if (VECTORED) begin : g_vec
            logic [W-1:0] offs;
            // interrupts in vectored mode land at base + 4*code
            always_comb begin
                offs   = (irq && vec[1:0] == 2'b01) ? W'({code, 2'b00}) : '0;
                target = base + offs;
            end
        end else begin : g_direct
            // direct mode only
            always_comb target = base;
        end
    endgenerate
endmodule

// File: rtl/trap_csr_file.sv
// Module: trap_csr_file
// Holds status, per-level cause/PC/value registers and the privilege.
// A trap in a cycle overrides any write in that cycle.
module trap_csr_file
    import trap_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trap_fire,
    input  logic          to_s,
    input  logic          irq,
    input  logic [CW-1:0] eff_code,
    input  logic [W-1:0]  cur_pc,
    input  logic [W-1:0]  tval,
    input  logic          we,
    input  logic [2:0]    sel,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [1:0]    priv
);
    localparam int LEVELS = 2;   // 0 supervisor, 1 machine

    logic         sie_q, mie_q, spie_q, mpie_q, spp_q;
    logic [1:0]   mpp_q, priv_q;
    logic [W-1:0] cause_q [LEVELS];
    logic [W-1:0] epc_q   [LEVELS];
    logic [W-1:0] tval_q  [LEVELS];
    logic [W-1:0] status_w;
    logic [W-1:0] cause_w;

    assign priv    = priv_q;
    assign cause_w = {irq, {(W-1-CW){1'b0}}, eff_code};

    // assemble the status image
    always_comb begin
        status_w              = '0;
        status_w[ST_SIE]      = sie_q;
        status_w[ST_MIE]      = mie_q;
        status_w[ST_SPIE]     = spie_q;
        status_w[ST_MPIE]     = mpie_q;
        status_w[ST_SPP]      = spp_q;
        status_w[ST_MPP+:2]   = mpp_q;
    end

    // status stack and privilege update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {sie_q, mie_q, spie_q, mpie_q, spp_q} <= '0;
            mpp_q  <= PRV_U;
            priv_q <= PRV_M;
        end else if (trap_fire) begin
            if (to_s) begin
                spie_q <= sie_q;
                spp_q  <= priv_q[0];
                sie_q  <= 1'b0;
                priv_q <= PRV_S;
            end else begin
                mpie_q <= mie_q;
                mpp_q  <= priv_q;
                mie_q  <= 1'b0;
                priv_q <= PRV_M;
            end
        end else if (we && sel == SEL_STATUS) begin
            sie_q  <= wdata[ST_SIE];
            mie_q  <= wdata[ST_MIE];
            spie_q <= wdata[ST_SPIE];
            mpie_q <= wdata[ST_MPIE];
            spp_q  <= wdata[ST_SPP];
            mpp_q  <= wdata[ST_MPP+:2];
        end else if (we && sel == SEL_PRIV) begin
            priv_q <= (wdata[1:0] == 2'd2) ? PRV_U : wdata[1:0];
        end
    end

    // one cause/PC/value bank per level
    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_lvl
            localparam logic [2:0] BASE = 3'(1 + 3 * g);
            logic hit;
            assign hit = trap_fire && (to_s == (g == 0));
            // bank load on trap, else port write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cause_q[g] <= '0;
                    epc_q[g]   <= '0;
                    tval_q[g]  <= '0;
                end else if (hit) begin
                    cause_q[g] <= cause_w;
                    epc_q[g]   <= cur_pc;
                    tval_q[g]  <= tval;
                end else if (we && !trap_fire) begin
                    if (sel == BASE)      cause_q[g] <= wdata;
                    if (sel == BASE + 3'd1) epc_q[g] <= wdata;
                    if (sel == BASE + 3'd2) tval_q[g] <= wdata;
                end
            end
        end
    endgenerate

    // read mux
    always_comb begin
        case (sel)
            3'd0:    rdata = status_w;
            3'd1:    rdata = cause_q[0];
            3'd2:    rdata = epc_q[0];
            3'd3:    rdata = tval_q[0];
            3'd4:    rdata = cause_q[1];
            3'd5:    rdata = epc_q[1];
            3'd6:    rdata = tval_q[1];
            default: rdata = {{(W-2){1'b0}}, priv_q};
        endcase
    end

    a_r7_priv_target: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire |=> priv_q == ($past(to_s) ? PRV_S : PRV_M));
    a_r7_mepc_load: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire && !to_s |=> epc_q[1] == $past(cur_pc));
    a_r4_s_stack: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire && to_s |=> !sie_q && spie_q == $past(sie_q) && $stable(mie_q));
    a_r5_m_stack: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire && !to_s |=> !mie_q && mpp_q == $past(priv_q) && $stable(sie_q));
    a_r11_priv_legal: assert property (@(posedge clk) disable iff (!rst_n)
        priv_q != 2'd2);
endmodule

// File: rtl/trap_entry_unit.sv
// Module: trap_entry_unit (top)
// Takes a trap in one cycle: routes it, computes the handler address
// and commits the register updates at the next clock edge.
// Assumes trap_req is a single-cycle pulse per trap taken.
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int W        = XLEN,
    parameter int CW       = CODE_W,
    parameter bit VECTORED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trap_req,
    input  logic          trap_irq,
    input  logic [CW-1:0] trap_code,
    input  logic [W-1:0]  cur_pc,
    input  logic [W-1:0]  fault_addr,
    input  logic [W-1:0]  irq_deleg,
    input  logic [W-1:0]  exc_deleg,
    input  logic [W-1:0]  s_vec,
    input  logic [W-1:0]  m_vec,
    output logic [W-1:0]  redirect_pc,
    input  logic          csr_we,
    input  logic [2:0]    csr_sel,
    input  logic [W-1:0]  csr_wdata,
    output logic [W-1:0]  csr_rdata,
    output logic [1:0]    cur_priv
);
    logic [CW-1:0] eff_code;
    logic          to_s;
    logic [W-1:0]  tval;

    trap_route #(.W(W), .CW(CW)) u_route (
        .irq(trap_irq), .code(trap_code), .priv(cur_priv),
        .irq_deleg(irq_deleg), .exc_deleg(exc_deleg), .fault_addr(fault_addr),
        .eff_code(eff_code), .to_s(to_s), .tval(tval)
    );

    trap_vector #(.W(W), .CW(CW), .VECTORED(VECTORED)) u_vec (
        .to_s(to_s), .irq(trap_irq), .code(eff_code),
        .s_vec(s_vec), .m_vec(m_vec), .target(redirect_pc)
    );

    trap_csr_file #(.W(W), .CW(CW)) u_csr (
        .clk(clk), .rst_n(rst_n), .trap_fire(trap_req), .to_s(to_s),
        .irq(trap_irq), .eff_code(eff_code), .cur_pc(cur_pc), .tval(tval),
        .we(csr_we), .sel(csr_sel), .wdata(csr_wdata),
        .rdata(csr_rdata), .priv(cur_priv)
    );

    a_r3_no_deleg_from_m: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && cur_priv == PRV_M |-> !to_s);
    a_r9_irq_tval_zero: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && trap_irq |-> tval == '0);
endmodule

// File: tb/trap_entry_unit_test.sv
`timescale 1ns/1ps
module trap_entry_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 0, trap_irq = 0;
    logic [4:0]  trap_code = 0;
    logic [31:0] cur_pc = 0, fault_addr = 0, irq_deleg = 0, exc_deleg = 0;
    logic [31:0] s_vec = 0, m_vec = 0, csr_wdata = 0;
    logic        csr_we = 0;
    logic [2:0]  csr_sel = 0;
    logic [31:0] redirect_pc, csr_rdata;
    logic [1:0]  cur_priv;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    trap_entry_unit uut (.*);

    // reference model state
    bit          m_sie, m_mie, m_spie, m_mpie, m_spp;
    bit [1:0]    m_mpp, m_priv;
    bit [31:0]   m_cause[2], m_epc[2], m_tval[2];

    task automatic model_reset();
        {m_sie, m_mie, m_spie, m_mpie, m_spp} = '0;
        m_mpp = 0; m_priv = 3;
        for (int i = 0; i < 2; i++) begin m_cause[i] = 0; m_epc[i] = 0; m_tval[i] = 0; end
    endtask

    function automatic bit [31:0] model_read(input bit [2:0] s);
        bit [31:0] st;
        st = 0; st[1] = m_sie; st[3] = m_mie; st[5] = m_spie; st[7] = m_mpie;
        st[8] = m_spp; st[12:11] = m_mpp;
        case (s)
            0: return st;
            1: return m_cause[0];
            2: return m_epc[0];
            3: return m_tval[0];
            4: return m_cause[1];
            5: return m_epc[1];
            6: return m_tval[1];
            default: return {30'd0, m_priv};
        endcase
    endfunction

    function automatic string tag_of(input bit [2:0] s);
        case (s)
            0: return "R4/R5 status";
            1, 4: return "R6 cause";
            2, 5: return "R7 epc";
            3, 6: return "R9 tval";
            default: return "R7 priv";
        endcase
    endfunction

    // decision taken by the model for the current inputs
    function automatic int rec_code();
        if (!trap_irq && trap_code == 8) return 8 + m_priv;
        return trap_code;
    endfunction
    function automatic bit model_to_s();
        bit [31:0] mk = trap_irq ? irq_deleg : exc_deleg;
        return (m_priv == 0 || m_priv == 1) && mk[rec_code()];
    endfunction

    task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: compare combinational outputs, then advance model
    task automatic tick();
        int c; bit ts; bit [31:0] v, tv; int l;
        #1;
        chk(tag_of(csr_sel), csr_rdata, model_read(csr_sel));
        chk("R7 priv port", {30'd0, cur_priv}, {30'd0, m_priv});
        c = rec_code(); ts = model_to_s();
        if (trap_req) begin
            v = ts ? s_vec : m_vec;
            chk("R8 redirect", redirect_pc,
                (v & ~32'd3) + ((trap_irq && v[1:0] == 1) ? c * 4 : 0));
        end
        @(posedge clk);
        if (!rst_n) model_reset();
        else if (trap_req) begin
            tv = (!trap_irq && (c inside {0,1,4,5,6,7,12,13,15})) ? fault_addr : 0;
            l = ts ? 0 : 1;
            m_cause[l] = {trap_irq, 26'd0, 5'(c)};
            m_epc[l] = cur_pc; m_tval[l] = tv;
            if (ts) begin m_spie = m_sie; m_spp = m_priv[0]; m_sie = 0; m_priv = 1; end
            else begin m_mpie = m_mie; m_mpp = m_priv; m_mie = 0; m_priv = 3; end
        end else if (csr_we) begin
            case (csr_sel)
                0: begin m_sie = csr_wdata[1]; m_mie = csr_wdata[3]; m_spie = csr_wdata[5];
                         m_mpie = csr_wdata[7]; m_spp = csr_wdata[8]; m_mpp = csr_wdata[12:11]; end
                1: m_cause[0] = csr_wdata;
                2: m_epc[0] = csr_wdata;
                3: m_tval[0] = csr_wdata;
                4: m_cause[1] = csr_wdata;
                5: m_epc[1] = csr_wdata;
                6: m_tval[1] = csr_wdata;
                default: m_priv = (csr_wdata[1:0] == 2) ? 0 : csr_wdata[1:0];
            endcase
        end
        @(negedge clk);
    endtask

    task automatic idle();
        trap_req = 0; csr_we = 0;
    endtask

    task automatic wr(input bit [2:0] s, input bit [31:0] d);
        idle(); csr_we = 1; csr_sel = s; csr_wdata = d; tick(); idle();
    endtask

    task automatic expect_reg(input bit [2:0] s, input bit [31:0] e, input string tag);
        idle(); csr_sel = s; #1; chk(tag, csr_rdata, e);
    endtask

    task automatic trap(input bit irq, input bit [4:0] code, input bit [31:0] pc,
                        input bit [31:0] fa, input bit [31:0] exp_pc, input string tag);
        idle(); trap_req = 1; trap_irq = irq; trap_code = code; cur_pc = pc; fault_addr = fa;
        #1; chk(tag, redirect_pc, exp_pc);
        tick(); idle();
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        for (int s = 0; s < 8; s++)
            expect_reg(3'(s), (s == 7) ? 32'd3 : 32'd0, "R1 reset value");
        @(negedge clk); rst_n = 1;

        // R11 port access
        wr(7, 0);            expect_reg(7, 0, "R11 priv write");
        wr(0, 32'hFFFF_FFFF); expect_reg(0, 32'h0000_19AA, "R11 status fields");
        wr(7, 2);            expect_reg(7, 0, "R11 priv 2 stored as 0");
        wr(5, 32'h1234);     expect_reg(5, 32'h1234, "R11 mepc write");

        // R2/R4 exception delegated from user
        wr(0, 32'h2);
        exc_deleg = 32'h2000; irq_deleg = 0; s_vec = 32'h8001; m_vec = 32'h4001;
        trap(0, 13, 32'h100, 32'hDEAD0000, 32'h8000, "R8 exception ignores vectoring");
        expect_reg(7, 1, "R7 priv to S");
        expect_reg(1, 13, "R2 cause in S bank");
        expect_reg(2, 32'h100, "R7 sepc");
        expect_reg(3, 32'hDEAD0000, "R9 stval address");
        expect_reg(0, 32'h20, "R4 status on S entry");
        expect_reg(5, 32'h1234, "R7 other bank kept");

        // R2 interrupt uses interrupt mask, vectored
        irq_deleg = 32'h20; exc_deleg = 0;
        trap(1, 5, 32'h200, 32'hFFFF, 32'h8014, "R8 vectored interrupt");
        expect_reg(1, 32'h8000_0005, "R6 interrupt cause");
        expect_reg(3, 0, "R9 irq tval zero");
        expect_reg(0, 32'h100, "R4 spp from S");

        // R2 exception ignores interrupt mask -> machine
        trap(0, 5, 32'h300, 32'hABC0, 32'h4000, "R8 machine direct");
        expect_reg(7, 3, "R2 exception not delegated by irq mask");
        expect_reg(4, 5, "R6 machine cause");
        expect_reg(6, 32'hABC0, "R9 mtval address");
        expect_reg(0, 32'h900, "R5 mpp from S");

        // R3 machine never delegates
        wr(0, 32'h8); irq_deleg = 32'hFFFF_FFFF;
        trap(1, 7, 32'h400, 0, 32'h401C, "R3 machine vectored");
        expect_reg(4, 32'h8000_0007, "R3 stays in machine bank");
        expect_reg(0, 32'h1880, "R5 status on M entry");

        // R10 environment call remapping
        exc_deleg = 32'hFFFF_FFFF;
        trap(0, 8, 32'h500, 32'h77, 32'h4000, "R10 ecall from M");
        expect_reg(4, 11, "R10 cause 11 from M");
        expect_reg(6, 0, "R9 ecall tval zero");
        wr(7, 0); exc_deleg = 32'h100;
        trap(0, 8, 32'h600, 0, 32'h8000, "R10 ecall from U");
        expect_reg(1, 8, "R10 cause 8 from U");
        exc_deleg = 32'h100;
        trap(0, 8, 32'h700, 0, 32'h4000, "R10 S ecall tests bit 9");
        expect_reg(4, 9, "R10 cause 9 from S");
        expect_reg(7, 3, "R10 undelegated goes to M");

        // R12 trap beats a same-cycle write
        idle(); trap_req = 1; trap_irq = 0; trap_code = 2; cur_pc = 32'h900;
        csr_we = 1; csr_sel = 5; csr_wdata = 32'hFFFF; tick(); idle();
        expect_reg(5, 32'h900, "R12 trap overrides write");
        expect_reg(6, 0, "R9 illegal code no address");

        // random phase compared against the model every clock
        for (int n = 0; n < 3000; n++) begin
            int pick;
            trap_req = ($urandom % 3) == 0;
            trap_irq = $urandom % 2;
            pick = $urandom % 14;
            trap_code = trap_irq ? 5'(1 + 2 * (pick % 6))
                                 : 5'(pick < 11 ? (pick == 3 ? 8 : pick) : pick + 1);
            cur_pc = $urandom; fault_addr = $urandom;
            irq_deleg = $urandom; exc_deleg = $urandom;
            s_vec = $urandom; m_vec = $urandom;
            if ($urandom % 2) s_vec[1:0] = 1;
            if ($urandom % 2) m_vec[1:0] = 1;
            csr_we = ($urandom % 3) == 0;
            csr_sel = $urandom; csr_wdata = $urandom;
            tick();
        end
        idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule